// File: doc/BRIEF.md
# Indexed Peripheral Generated-Clock Controller

This block keeps a generated-clock configuration for each of up to 64 peripherals and reaches all of them through a single 32-bit control word. Software first writes a peripheral number with the command bit clear. That write only points the control word at the peripheral, and a read then returns that peripheral's stored source, divider and enable. A write with the command bit set commits new settings to the peripheral it names. The new settings land in the table on the clock after the write.

Each valid peripheral owns a divider. The divider picks one of the source-clock qualifiers (`src_tick`, one-cycle strobes in the system clock domain) and counts its strobes. It emits one `clk_en` pulse every (divider + 1) strobes, so the consumer gets a gated clock enable with a ratio from 1 to 256. While a divider is running, a change of ratio or source is held back until the current period ends. This avoids shortened periods.

The register interface uses two states. `RI_IDLE` waits for a write. `RI_COMMIT` applies a latched command to the table, and a write that arrives in that cycle is accepted as usual. The transitions are: any command write goes to `RI_COMMIT`; any other cycle goes to `RI_IDLE`. Each divider also has two states. `DV_STOP` means disabled; in it the active settings track the table and the count is zero. `DV_RUN` means counting. A divider goes from `DV_STOP` to `DV_RUN` when the stored enable is set. It goes from `DV_RUN` back to `DV_STOP` when the stored enable is cleared.

Top module: `gclk_ctrl`

## Requirements
- R1: A write with bit 12 clear loads the peripheral number from bits [5:0] into the selection and changes no stored setting of any peripheral.
- R2: `rdata` shows the selected number in [5:0], its source in [10:8], its divider in [27:20] and its enable in bit 28; all other bits read 0.
- R3: A write with bit 12 set and bit 28 set stores source, divider and enable together for the peripheral in [5:0]. The new values are readable from the cycle after the write.
- R4: A write with bit 12 set and bit 28 clear clears only the enable and keeps the stored source and divider. A disabled peripheral's `clk_en` stays low.
- R5: A running peripheral with divider D emits exactly one `clk_en` pulse per D+1 strobes of its source. D=0 follows the source strobe (constantly high for a constant strobe), and D=255 gives division by 256.
- R6: Source codes 0 to 5 select `src_tick[code]`. Codes 6 and 7 are stored and read back but produce no `clk_en` pulse.
- R7: Peripheral numbers 0 and 1 ignore commits, always read back source, divider and enable as 0, and their `clk_en` bits stay 0.
- R8: After reset every peripheral has source 0, divider 0 and enable 0, the selection is 0, and all `clk_en` bits are low.
- R9: A new divider or source committed to a running peripheral takes effect only after the current period's final pulse. A disabled peripheral adopts it at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control word write strobe |
| wdata | input | 32 | Control word write data |
| rdata | output | 32 | Control word read data for the selected peripheral |
| src_tick | input | NUM_SRC | Per-source one-cycle clock qualifiers |
| clk_en | output | NUM_PERIPH | Per-peripheral generated clock enable pulses |

## Verification
Corruption of the settings table shows up on `rdata` one cycle after a commit or selection, because the read path is combinational from the stored entry. A divider that holds a wrong count or wrong active settings shows up in `clk_en`. It gives a pulse count over a window of whole periods that differs from the ideal ratio, and the error appears within one period of the selected ratio. A divider that swaps settings too early shows up as a pulse inside the old period, right after the commit.

// File: rtl/gclk_pkg.sv
package gclk_pkg;
    localparam int DATA_W  = 32;
    localparam int SRC_W   = 3;
    localparam int DIV_W   = 8;
    localparam int ID_LSB  = 0;
    localparam int SRC_LSB = 8;
    localparam int CMD_BIT = 12;
    localparam int DIV_LSB = 20;
    localparam int EN_BIT  = 28;

    typedef struct packed {
        logic             en;
        logic [DIV_W-1:0] div;
        logic [SRC_W-1:0] src;
    } gclk_cfg_t;

    typedef enum logic {RI_IDLE, RI_COMMIT} regif_state_e;
    typedef enum logic {DV_STOP, DV_RUN}    div_state_e;
endpackage

// File: rtl/gclk_regif.sv
module gclk_regif
    import gclk_pkg::*;
#(
    parameter int NUM_PERIPH = 64,
    parameter int FIRST_ID   = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [DATA_W-1:0]           wdata,
    output logic [DATA_W-1:0]           rdata,
    output gclk_cfg_t [NUM_PERIPH-1:0]  cfg_o,
    output logic                        commit_o
);
    localparam int ID_W = $clog2(NUM_PERIPH);

    regif_state_e    state_q, state_d;
    logic [ID_W-1:0] sel_id_q;
    gclk_cfg_t       pend_q;
    gclk_cfg_t       cur;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RI_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = RI_IDLE;
        unique case (state_q)
            RI_IDLE:   state_d = (wr_en && wdata[CMD_BIT]) ? RI_COMMIT : RI_IDLE;
            RI_COMMIT: state_d = (wr_en && wdata[CMD_BIT]) ? RI_COMMIT : RI_IDLE;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        commit_o = (state_q == RI_COMMIT);
    end

    // selection and pending command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_id_q <= '0;
            pend_q   <= '0;
        end else if (wr_en) begin
            sel_id_q   <= wdata[ID_LSB +: ID_W];
            pend_q.src <= wdata[SRC_LSB +: SRC_W];
            pend_q.div <= wdata[DIV_LSB +: DIV_W];
            pend_q.en  <= wdata[EN_BIT];
        end
    end

    // settings table, one entry per peripheral
    for (genvar g = 0; g < NUM_PERIPH; g++) begin : g_ent
        if (g < FIRST_ID) begin : g_rsvd
            assign cfg_o[g] = '0;
        end else begin : g_live
            gclk_cfg_t ent_q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ent_q <= '0;
                end else if (commit_o && sel_id_q == ID_W'(g)) begin
                    if (pend_q.en) ent_q    <= pend_q;
                    else           ent_q.en <= 1'b0;
                end
            end
            assign cfg_o[g] = ent_q;
        end
    end

    // read path
    always_comb begin
        cur   = cfg_o[sel_id_q];
        rdata = '0;
        rdata[ID_LSB  +: ID_W]  = sel_id_q;
        rdata[SRC_LSB +: SRC_W] = cur.src;
        rdata[DIV_LSB +: DIV_W] = cur.div;
        rdata[EN_BIT]           = cur.en;
    end
endmodule

// File: rtl/gclk_div.sv
module gclk_div
    import gclk_pkg::*;
#(
    parameter int NUM_SRC = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  gclk_cfg_t          cfg_i,
    input  logic [NUM_SRC-1:0] src_tick_i,
    output logic               tick_o
);
    div_state_e       state_q, state_d;
    logic [SRC_W-1:0] act_src_q;
    logic [DIV_W-1:0] act_div_q;
    logic [DIV_W-1:0] cnt_q;
    logic             src_ok;
    logic             sel_tick;
    logic             term;

    always_comb begin
        src_ok   = 1'b0;
        sel_tick = 1'b0;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (act_src_q == SRC_W'(s)) begin
                src_ok   = 1'b1;
                sel_tick = src_tick_i[s];
            end
        end
        term = (cnt_q == act_div_q);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= DV_STOP;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = DV_STOP;
        unique case (state_q)
            DV_STOP: state_d = cfg_i.en ? DV_RUN : DV_STOP;
            DV_RUN:  state_d = cfg_i.en ? DV_RUN : DV_STOP;
        endcase
    end

    // counter and active settings
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_src_q <= '0;
            act_div_q <= '0;
            cnt_q     <= '0;
        end else begin
            unique case (state_q)
                DV_STOP: begin
                    act_src_q <= cfg_i.src;
                    act_div_q <= cfg_i.div;
                    cnt_q     <= '0;
                end
                DV_RUN: begin
                    if (!cfg_i.en || !src_ok) begin
                        act_src_q <= cfg_i.src;
                        act_div_q <= cfg_i.div;
                        cnt_q     <= '0;
                    end else if (sel_tick) begin
                        if (term) begin
                            act_src_q <= cfg_i.src;
                            act_div_q <= cfg_i.div;
                            cnt_q     <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    // output
    always_comb begin
        tick_o = (state_q == DV_RUN) && cfg_i.en && sel_tick && term;
    end
endmodule

// File: rtl/gclk_ctrl.sv
module gclk_ctrl
    import gclk_pkg::*;
#(
    parameter int NUM_PERIPH = 64,
    parameter int NUM_SRC    = 6,
    parameter int FIRST_ID   = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [DATA_W-1:0]     wdata,
    output logic [DATA_W-1:0]     rdata,
    input  logic [NUM_SRC-1:0]    src_tick,
    output logic [NUM_PERIPH-1:0] clk_en
);
    gclk_cfg_t [NUM_PERIPH-1:0] cfg_w;
    logic                       commit_w;

    gclk_regif #(
        .NUM_PERIPH(NUM_PERIPH),
        .FIRST_ID  (FIRST_ID)
    ) u_regif (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wdata   (wdata),
        .rdata   (rdata),
        .cfg_o   (cfg_w),
        .commit_o(commit_w)
    );

    for (genvar g = 0; g < NUM_PERIPH; g++) begin : g_div
        if (g < FIRST_ID) begin : g_none
            assign clk_en[g] = 1'b0;
        end else begin : g_gen
            gclk_div #(.NUM_SRC(NUM_SRC)) u_div (
                .clk       (clk),
                .rst_n     (rst_n),
                .cfg_i     (cfg_w[g]),
                .src_tick_i(src_tick),
                .tick_o    (clk_en[g])
            );
        end
    end
endmodule

// File: rtl/gclk_ctrl_chk.sv
module gclk_ctrl_chk
    import gclk_pkg::*;
#(
    parameter int NUM_PERIPH = 64,
    parameter int FIRST_ID   = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       wr_en,
    input logic [DATA_W-1:0]          wdata,
    input logic [DATA_W-1:0]          rdata,
    input logic [NUM_PERIPH-1:0]      clk_en,
    input gclk_cfg_t [NUM_PERIPH-1:0] cfg,
    input logic                       commit
);
    // R1: selection-only write leaves the table untouched
    a_r1_select_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wdata[CMD_BIT] && !commit) |=> $stable(cfg));

    // R2: bits outside the fields read as zero
    a_r2_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata & 32'hE00F_F8C0) == 32'h0);

    for (genvar g = 0; g < NUM_PERIPH; g++) begin : g_p
        if (g < FIRST_ID) begin : g_rsvd
            // R7: reserved numbers stay empty and silent
            a_r7_rsvd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg[g] == '0) && !clk_en[g]);
        end else begin : g_live
            // R4: a disabled peripheral gives no pulse
            a_r4_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
                !cfg[g].en |-> !clk_en[g]);
            // R4: clearing the enable keeps source and divider
            a_r4_keep_fields: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(cfg[g].en) |-> ($stable(cfg[g].div) && $stable(cfg[g].src)));
        end
    end
endmodule

bind gclk_ctrl gclk_ctrl_chk #(
    .NUM_PERIPH(NUM_PERIPH),
    .FIRST_ID  (FIRST_ID)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .wdata (wdata),
    .rdata (rdata),
    .clk_en(clk_en),
    .cfg   (cfg_w),
    .commit(commit_w)
);

// File: tb/gclk_ctrl_test.sv
`timescale 1ns/1ps
module gclk_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [5:0]  src_tick = 6'b000001;
    logic [63:0] clk_en;
    logic [7:0]  ph = '0;
    int          total = 0;
    int          bad = 0;

    gclk_ctrl uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata),
        .rdata(rdata), .src_tick(src_tick), .clk_en(clk_en)
    );

    always #5 clk = ~clk;

    // source strobes: 0 always, 1 every 2nd cycle, 2 every 3rd cycle, 3..5 always
    always @(posedge clk) begin
        #1;
        ph = ph + 8'd1;
        src_tick = {3'b111, (ph % 3 == 0), ~ph[0], 1'b1};
    end

    task automatic chk(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input int id, input bit cmd, input int src,
                                       input int div, input bit en);
        return (32'(en) << 28) | (32'(div & 255) << 20) | (32'(cmd) << 12)
             | (32'(src & 7) << 8) | 32'(id & 63);
    endfunction

    task automatic wr(input int id, input bit cmd, input int src, input int div, input bit en);
        @(negedge clk);
        wr_en = 1'b1;
        wdata = mk(id, cmd, src, div, en);
        @(negedge clk);
        wr_en = 1'b0;
        wdata = '0;
        @(negedge clk);
    endtask

    task automatic count(input int id, input int len, output int n);
        n = 0;
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            if (clk_en[id]) n++;
        end
    endtask

    task automatic t_reset();
        int n;
        chk("R8 rdata after reset", rdata, 0);
        chk("R8 clk_en after reset", clk_en, 0);
        wr(5, 0, 0, 0, 0);
        chk("R8 peripheral 5 reset settings", rdata, mk(5, 0, 0, 0, 0));
        count(5, 8, n);
        chk("R8 no pulses after reset", n, 0);
    endtask

    task automatic t_select();
        wr(7, 1, 3, 9, 1);
        chk("R3 commit read back", rdata, mk(7, 0, 3, 9, 1));
        wr(7, 0, 5, 77, 0);
        chk("R1 id-only write keeps fields", rdata, mk(7, 0, 3, 9, 1));
        chk("R2 id field", rdata[5:0], 7);
        wr(8, 0, 2, 4, 1);
        chk("R1 select other peripheral", rdata, mk(8, 0, 0, 0, 0));
        wr(7, 0, 0, 0, 0);
        chk("R2 full word layout", rdata, 32'h1090_0307);
    endtask

    task automatic t_ratio(input int id, input int div, input int len, input int exp);
        int n;
        wr(id, 1, 0, div, 1);
        @(negedge clk);
        count(id, len, n);
        chk($sformatf("R5 ratio div=%0d", div), n, exp);
    endtask

    task automatic t_div1_high();
        int hi;
        hi = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (clk_en[10]) hi++;
        end
        chk("R5 divide by 1 stays high", hi, 10);
    endtask

    task automatic t_source();
        int n;
        wr(20, 1, 1, 1, 1);
        @(negedge clk);
        count(20, 12, n);
        chk("R6 source 1 divided by 2", n, 3);
        wr(21, 1, 2, 0, 1);
        @(negedge clk);
        count(21, 12, n);
        chk("R6 source 2 undivided", n, 4);
        wr(22, 1, 6, 0, 1);
        chk("R6 code 6 stored", rdata, mk(22, 0, 6, 0, 1));
        count(22, 20, n);
        chk("R6 code 6 silent", n, 0);
        wr(23, 1, 7, 0, 1);
        count(23, 20, n);
        chk("R6 code 7 silent", n, 0);
    endtask

    task automatic t_disable();
        int n;
        wr(30, 1, 1, 2, 1);
        @(negedge clk);
        count(30, 12, n);
        chk("R4 running before disable", n, 2);
        wr(30, 1, 0, 0, 0);
        chk("R4 disable keeps fields", rdata, mk(30, 0, 1, 2, 0));
        count(30, 16, n);
        chk("R4 no pulses when disabled", n, 0);
    endtask

    task automatic t_bad_id();
        int n;
        wr(1, 1, 2, 5, 1);
        chk("R7 id 1 reads zero", rdata, mk(1, 0, 0, 0, 0));
        wr(0, 1, 0, 0, 1);
        chk("R7 id 0 reads zero", rdata, mk(0, 0, 0, 0, 0));
        count(0, 10, n);
        chk("R7 id 0 silent", n, 0);
        count(1, 10, n);
        chk("R7 id 1 silent", n, 0);
    endtask

    task automatic t_no_runt();
        int n;
        wr(40, 1, 0, 255, 1);
        repeat (10) @(negedge clk);
        wr(40, 1, 0, 0, 1);
        chk("R3 new divider readable", rdata, mk(40, 0, 0, 0, 1));
        count(40, 30, n);
        chk("R9 old period kept", n, 0);
        repeat (300) @(negedge clk);
        count(40, 12, n);
        chk("R9 new divider after terminal", n, 12);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        fork
            begin
                t_reset();
                t_select();
                t_ratio(10, 0, 12, 12);
                t_div1_high();
                t_ratio(11, 1, 12, 6);
                t_ratio(12, 2, 12, 4);
                t_ratio(13, 255, 768, 3);
                t_source();
                t_disable();
                t_bad_id();
                t_no_runt();
            end
            begin
                repeat (100000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule